// File: doc/BRIEF.md
# Post-Reset ECC Scrub Engine

This block sits between client logic and a single-port synchronous RAM whose words carry eight data bits and five check bits. When reset is released it sweeps every address in ascending order. For each address it reads the stored word, passes it through a single-error-correcting, double-error-detecting decoder, and writes the result back to the same address. Once the last address has been written back, a done flag rises and stays high until the next reset. Client logic waits for this flag before it touches the memory.

During the sweep the engine alone drives the RAM, and client requests have no effect. After the sweep the client drives the RAM port directly. Client writes are encoded on the way in. Client reads are decoded on the way out, so a single flipped bit in a word is repaired in the returned data. The engine also counts the words it repaired, with a count that saturates rather than wrapping. It keeps a sticky flag for any word that holds an error it cannot correct.

Top module: `scrub_top`

## Requirements
- R1: A stored 13-bit word has this layout. Data bits d0..d7 sit at bit indices 3, 5, 6, 7, 9, 10, 11 and 12. The check bit at index 1, 2, 4 or 8 is the XOR of the data bits whose index has that bit set. Bit 0 is the XOR of bits 12..1, so the whole word has even parity.
- R2: After reset is released, addresses 0 to DEPTH-1 are visited in ascending order. Each visit takes three cycles: a read, a correct step, then a write back to the same address.
- R3: A word with exactly one flipped bit, at any of the 13 positions, is written back as the correct codeword.
- R4: A word that shows a double-bit error (nonzero syndrome with even overall parity) is written back unchanged. It also sets `dbl_err_seen`, which stays high until reset.
- R5: A word with no error is written back unchanged.
- R6: `init_done` rises exactly 3*DEPTH cycles after reset is released and stays high until the next reset.
- R7: `fix_count` counts the words repaired during the sweep and holds at 2^FIX_W-1 once it reaches that value.
- R8: While `init_done` is low, client requests are ignored: they cause no RAM write and no `cli_rvalid`.
- R9: Once `init_done` is high, a client write stores the R1 codeword of `cli_wdata`. A client read raises `cli_rvalid` one cycle after the request, with the corrected data on `cli_rdata` in that same cycle.
- R10: While reset is low, `init_done`, `dbl_err_seen`, `fix_count` and `mem_we` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cli_req | input | 1 | Client access request |
| cli_we | input | 1 | Client request is a write |
| cli_addr | input | AW | Client word address |
| cli_wdata | input | 8 | Client write data |
| cli_rdata | output | 8 | Corrected client read data |
| cli_rvalid | output | 1 | Client read data is valid this cycle |
| mem_addr | output | AW | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | 13 | RAM write word |
| mem_rdata | input | 13 | RAM read word, registered one cycle after the address |
| init_done | output | 1 | Sweep complete; memory is safe to use |
| dbl_err_seen | output | 1 | Sticky flag for an uncorrectable word |
| fix_count | output | FIX_W | Saturating count of repaired words |

## Verification
Each result has a fixed cycle in which it is due, and every check samples in that cycle. `init_done` must first read high on the falling edge after rising edge 3*DEPTH, counted from reset release. A sweep write-back must carry the address that was read two cycles earlier. `cli_rvalid` and `cli_rdata` are due on the falling edge after the edge that took the read request. A client write lands in the RAM model at the next rising edge. Inputs change only on falling edges, after the outputs have been sampled, so no check depends on the order of processes at a clock edge.

// File: rtl/scrub_pkg.sv
// Shared constants and types for the post-reset scrub engine.
// Assumes a fixed 8-bit data field protected by a 13-bit SECDED code.
package scrub_pkg;
    localparam int DATA_W = 8;
    localparam int CODE_W = 13;
    localparam int CHK_N  = 4;
    // bit index inside a codeword that holds each data bit
    localparam int DPOS [DATA_W] = '{3, 5, 6, 7, 9, 10, 11, 12};

    typedef enum logic [1:0] {
        ST_READ  = 2'd0,
        ST_FIX   = 2'd1,
        ST_WBACK = 2'd2,
        ST_IDLE  = 2'd3
    } scrub_state_t;
endpackage

// File: rtl/secded_enc.sv
// Builds a 13-bit SECDED codeword from 8 data bits.
// Assumes the package layout: checks at the power-of-two indices, overall parity at bit 0.
module secded_enc
    import scrub_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    output logic [CODE_W-1:0] cw
);
    // place the data bits, then derive each check bit and the overall parity
    always_comb begin
        cw = '0;
        for (int k = 0; k < DATA_W; k++) begin
            cw[DPOS[k]] = din[k];
        end
        for (int j = 0; j < CHK_N; j++) begin
            logic acc;
            acc = 1'b0;
            for (int p = 1; p < CODE_W; p++) begin
                if (((p >> j) & 1) == 1 && p != (1 << j)) acc = acc ^ cw[p];
            end
            cw[1 << j] = acc;
        end
        cw[0] = ^cw[CODE_W-1:1];
    end
endmodule

// File: rtl/secded_dec.sv
// Decodes a 13-bit SECDED word: repairs a single flipped bit and flags double errors.
// Assumes even overall parity across the whole word when it is error free.
module secded_dec
    import scrub_pkg::*;
(
    input  logic [CODE_W-1:0] cw_in,
    output logic [CODE_W-1:0] cw_fixed,
    output logic [DATA_W-1:0] dout,
    output logic              err_single,
    output logic              err_double
);
    logic [CHK_N-1:0] syn;
    logic             par;

    // syndrome is the XOR of the indices of all set bits above bit 0
    always_comb begin
        syn = '0;
        for (int p = 1; p < CODE_W; p++) begin
            if (cw_in[p]) syn = syn ^ CHK_N'(p);
        end
        par = ^cw_in;
    end

    // classify the error and repair a single flipped bit
    always_comb begin
        cw_fixed   = cw_in;
        err_single = 1'b0;
        err_double = 1'b0;
        if (par) begin
            if (int'(syn) < CODE_W) begin
                cw_fixed   = cw_in ^ (CODE_W'(1) << syn);
                err_single = 1'b1;
            end else begin
                err_double = 1'b1;
            end
        end else if (syn != '0) begin
            err_double = 1'b1;
        end
    end

    // pull the data field out of the repaired word
    always_comb begin
        for (int k = 0; k < DATA_W; k++) begin
            dout[k] = cw_fixed[DPOS[k]];
        end
    end
endmodule

// File: rtl/scrub_seq.sv
// Sweep sequencer: walks all addresses with read, fix, write-back steps, then idles with done high.
// Assumes the RAM returns read data one cycle after the address is presented.
module scrub_seq
    import scrub_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int FIX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] fixed_word,
    input  logic              saw_single,
    input  logic              saw_double,
    output logic [AW-1:0]     sw_addr,
    output logic              sw_we,
    output logic [CODE_W-1:0] sw_wdata,
    output logic              done,
    output logic              dbl_seen,
    output logic [FIX_W-1:0]  fixes
);
    localparam logic [AW-1:0]    LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [FIX_W-1:0] FIX_MAX   = '1;

    scrub_state_t      state;
    logic [AW-1:0]     addr;
    logic [CODE_W-1:0] hold;

    // step through read, fix and write-back for each address, then idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_READ;
            addr     <= '0;
            hold     <= '0;
            done     <= 1'b0;
            dbl_seen <= 1'b0;
            fixes    <= '0;
        end else begin
            case (state)
                ST_READ: state <= ST_FIX;
                ST_FIX: begin
                    hold <= fixed_word;
                    if (saw_single && fixes != FIX_MAX) fixes <= fixes + 1'b1;
                    if (saw_double) dbl_seen <= 1'b1;
                    state <= ST_WBACK;
                end
                ST_WBACK: begin
                    if (addr == LAST_ADDR) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        addr  <= addr + 1'b1;
                        state <= ST_READ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // memory drive while the sweep owns the port
    assign sw_addr  = addr;
    assign sw_we    = (state == ST_WBACK);
    assign sw_wdata = hold;
endmodule

// File: rtl/scrub_top.sv
// Top of the post-reset scrub engine: owns the RAM port during the sweep, then hands it to the client.
// Assumes a single-port synchronous RAM outside this block with one cycle of read latency.
module scrub_top
    import scrub_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int FIX_W = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cli_req,
    input  logic              cli_we,
    input  logic [AW-1:0]     cli_addr,
    input  logic [DATA_W-1:0] cli_wdata,
    output logic [DATA_W-1:0] cli_rdata,
    output logic              cli_rvalid,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic [CODE_W-1:0] mem_wdata,
    input  logic [CODE_W-1:0] mem_rdata,
    output logic              init_done,
    output logic              dbl_err_seen,
    output logic [FIX_W-1:0]  fix_count
);
    logic [CODE_W-1:0] enc_word;
    logic [CODE_W-1:0] dec_fixed;
    logic              dec_single;
    logic              dec_double;
    logic [AW-1:0]     sw_addr;
    logic              sw_we;
    logic [CODE_W-1:0] sw_wdata;

    secded_enc u_enc (
        .din (cli_wdata),
        .cw  (enc_word)
    );

    secded_dec u_dec (
        .cw_in      (mem_rdata),
        .cw_fixed   (dec_fixed),
        .dout       (cli_rdata),
        .err_single (dec_single),
        .err_double (dec_double)
    );

    scrub_seq #(.DEPTH(DEPTH), .AW(AW), .FIX_W(FIX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fixed_word (dec_fixed),
        .saw_single (dec_single),
        .saw_double (dec_double),
        .sw_addr    (sw_addr),
        .sw_we      (sw_we),
        .sw_wdata   (sw_wdata),
        .done       (init_done),
        .dbl_seen   (dbl_err_seen),
        .fixes      (fix_count)
    );

    // RAM port ownership: sweep until done, client afterwards
    always_comb begin
        if (init_done) begin
            mem_addr  = cli_addr;
            mem_we    = cli_req && cli_we;
            mem_wdata = enc_word;
        end else begin
            mem_addr  = sw_addr;
            mem_we    = sw_we;
            mem_wdata = sw_wdata;
        end
    end

    // flag client read data one cycle after an accepted read request
    always_ff @(posedge clk) begin
        if (!rst_n) cli_rvalid <= 1'b0;
        else        cli_rvalid <= init_done && cli_req && !cli_we;
    end
endmodule

// File: rtl/scrub_top_chk.sv
// Property checker for scrub_top, attached by bind; observes ports only.
// Assumes reset is held low for at least one clock edge at start-up.
module scrub_top_chk #(
    parameter int AW    = 8,
    parameter int FIX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cli_req,
    input logic             cli_we,
    input logic             cli_rvalid,
    input logic [AW-1:0]    mem_addr,
    input logic             mem_we,
    input logic             init_done,
    input logic             dbl_err_seen,
    input logic [FIX_W-1:0] fix_count
);
    p_wback_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !init_done) |-> mem_addr == $past(mem_addr, 2));

    p_dbl_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_err_seen |=> dbl_err_seen);

    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_count_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fix_count >= $past(fix_count));

    p_no_rvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |=> !cli_rvalid);

    p_rvalid_due_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && cli_req && !cli_we) |=> cli_rvalid);
endmodule

bind scrub_top scrub_top_chk #(.AW(AW), .FIX_W(FIX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cli_req      (cli_req),
    .cli_we       (cli_we),
    .cli_rvalid   (cli_rvalid),
    .mem_addr     (mem_addr),
    .mem_we       (mem_we),
    .init_done    (init_done),
    .dbl_err_seen (dbl_err_seen),
    .fix_count    (fix_count)
);

// File: tb/scrub_top_test.sv
module scrub_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;
    localparam int FIX_W      = 4;
    localparam int AW         = 8;
    localparam int NVEC       = 9;
    // {address, flip mask applied to the clean codeword}
    localparam logic [20:0] VEC [NVEC] = '{
        {8'd0,   13'h0001}, {8'd5,   13'h0002}, {8'd17,  13'h0008},
        {8'd33,  13'h1000}, {8'd255, 13'h0100}, {8'd64,  13'h0000},
        {8'd90,  13'h0028}, {8'd200, 13'h0081}, {8'd128, 13'h0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cli_req = 1'b0, cli_we = 1'b0;
    logic [AW-1:0] cli_addr = '0;
    logic [7:0] cli_wdata = '0;
    logic [7:0] cli_rdata;
    logic cli_rvalid;
    logic [AW-1:0] mem_addr;
    logic mem_we;
    logic [12:0] mem_wdata;
    logic [12:0] mem_rdata;
    logic init_done, dbl_err_seen;
    logic [FIX_W-1:0] fix_count;

    logic ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [12:0] ld_data = '0;
    logic [12:0] ram [DEPTH];

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // RAM model: bench load port has priority over the design port
    always @(posedge clk) begin
        if (ld_en) ram[ld_addr] <= ld_data;
        else if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    scrub_top #(.DEPTH(DEPTH), .FIX_W(FIX_W)) uut (
        .clk(clk), .rst_n(rst_n), .cli_req(cli_req), .cli_we(cli_we),
        .cli_addr(cli_addr), .cli_wdata(cli_wdata), .cli_rdata(cli_rdata),
        .cli_rvalid(cli_rvalid), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .init_done(init_done),
        .dbl_err_seen(dbl_err_seen), .fix_count(fix_count)
    );

    // R1 codeword by explicit equations
    function automatic logic [12:0] enc(input logic [7:0] d);
        logic [12:0] c;
        c = '0;
        c[3] = d[0]; c[5] = d[1]; c[6] = d[2]; c[7] = d[3];
        c[9] = d[4]; c[10] = d[5]; c[11] = d[6]; c[12] = d[7];
        c[1] = c[3] ^ c[5] ^ c[7] ^ c[9] ^ c[11];
        c[2] = c[3] ^ c[6] ^ c[7] ^ c[10] ^ c[11];
        c[4] = c[5] ^ c[6] ^ c[7] ^ c[12];
        c[8] = c[9] ^ c[10] ^ c[11] ^ c[12];
        c[0] = ^c[12:1];
        return c;
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37) + 11);
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] flip_for(input int a, input int run);
        logic [12:0] f;
        f = '0;
        for (int i = 0; i < NVEC; i++) begin
            if (int'(VEC[i][20:13]) == a && (run == 2 || $countones(VEC[i][12:0]) <= 1))
                f = VEC[i][12:0];
        end
        if (run == 2 && a >= 100 && a < 115) f = 13'(1) << (a % 13);
        return f;
    endfunction

    task automatic preload(input int run);
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = AW'(a); ld_data = enc(pat(a)) ^ flip_for(a, run);
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // runs the sweep; optionally pokes client requests mid-sweep (R8)
    task automatic sweep(input bit poke);
        int cycles = 0;
        int exp_a  = 0;
        int bad    = 0;
        rst_n = 1'b1;
        while (!init_done && cycles < 5000) begin
            @(negedge clk);
            cycles++;
            if (mem_we && !init_done) begin
                if (int'(mem_addr) != exp_a) bad++;
                exp_a++;
            end
            if (poke && cycles > 601 && cycles < 606) begin
                if (cli_rvalid) bad++;
            end
            if (poke) begin
                cli_req   = (cycles == 600 || cycles == 603);
                cli_we    = (cycles == 600);
                cli_addr  = 8'd1;
                cli_wdata = 8'hA5;
            end
        end
        cli_req = 1'b0; cli_we = 1'b0;
        chk(cycles == 3*DEPTH, "R6 done cycle", cycles, 3*DEPTH);
        chk(bad == 0 && exp_a == DEPTH, "R2 sweep order / R8 no rvalid", bad, 0);
    endtask

    task automatic cli_read(input int a, output logic [7:0] d, output logic v);
        @(negedge clk);
        cli_req = 1'b1; cli_we = 1'b0; cli_addr = AW'(a);
        @(negedge clk);
        v = cli_rvalid; d = cli_rdata;
        cli_req = 1'b0;
    endtask

    task automatic check_vectors(input int run);
        logic [7:0] d;
        logic v;
        for (int i = 0; i < NVEC; i++) begin
            int a = int'(VEC[i][20:13]);
            logic [12:0] f = flip_for(a, run);
            if ($countones(f) == 2) begin
                chk(ram[a] == (enc(pat(a)) ^ f), "R4 double kept", ram[a], enc(pat(a)) ^ f);
            end else begin
                chk(ram[a] == enc(pat(a)), (f == 0) ? "R5 clean kept" : "R3 single fixed",
                    ram[a], enc(pat(a)));
                cli_read(a, d, v);
                chk(v && d == pat(a), "R9 client read", {v, d}, {1'b1, pat(a)});
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic v;
        // run 1: singles and clean words only
        preload(1);
        chk(!init_done && !dbl_err_seen && fix_count == 0 && !mem_we, "R10 reset state",
            {init_done, dbl_err_seen, fix_count, mem_we}, 0);
        sweep(1'b0);
        chk(fix_count == 5, "R7 count 5", fix_count, 5);
        chk(!dbl_err_seen, "R4 no double flag", dbl_err_seen, 0);
        check_vectors(1);
        for (int a = 0; a < DEPTH; a++) begin
            if (ram[a] != enc(pat(a))) begin
                chk(1'b0, "R3/R5 full array", ram[a], enc(pat(a)));
                break;
            end
        end
        // R9: client write then read back
        @(negedge clk);
        cli_req = 1'b1; cli_we = 1'b1; cli_addr = 8'd50; cli_wdata = 8'h3C;
        @(negedge clk);
        cli_req = 1'b0; cli_we = 1'b0;
        chk(ram[50] == enc(8'h3C), "R9 write encoded", ram[50], enc(8'h3C));
        cli_read(50, d, v);
        chk(v && d == 8'h3C, "R9 read back", {v, d}, {1'b1, 8'h3C});
        // R9: single flip injected after the sweep is repaired on read
        @(negedge clk);
        ld_en = 1'b1; ld_addr = 8'd60; ld_data = enc(pat(60)) ^ 13'h0040;
        @(negedge clk);
        ld_en = 1'b0;
        cli_read(60, d, v);
        chk(v && d == pat(60), "R9 read repair", {v, d}, {1'b1, pat(60)});
        chk(init_done, "R6 done held", init_done, 1);

        // run 2: doubles plus enough singles to saturate the count
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!init_done && !dbl_err_seen && fix_count == 0, "R10 reset clears",
            {init_done, dbl_err_seen, fix_count}, 0);
        preload(2);
        sweep(1'b1);
        chk(fix_count == 4'hF, "R7 saturate", fix_count, 4'hF);
        chk(dbl_err_seen, "R4 double flag", dbl_err_seen, 1);
        check_vectors(2);
        chk(ram[1] == enc(pat(1)), "R8 write ignored", ram[1], enc(pat(1)));
        cli_read(1, d, v);
        chk(v && d == pat(1), "R8 data unchanged", {v, d}, {1'b1, pat(1)});
        repeat (3) @(negedge clk);
        chk(dbl_err_seen && init_done, "R4 flag sticky", {dbl_err_seen, init_done}, 2'b11);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule